// File: doc/BRIEF.md
# Reclocker Output Path Selector

This block chooses what leaves a multi-input serial reclocker. A two-bit select code picks one of four serial inputs. The output then carries one of two things. The bypass path sends the chosen input straight through, with no register. The reclock path sends a data bit retimed by the recovered clock. Which one is used depends on a forced-bypass control, an automatic-bypass control and the lock status of the clock recovery loop. An active-low mute can silence the reclock path.

The priority is fixed. A forced bypass always wins. An automatic bypass takes effect only while lock is absent. The mute acts only on the reclock path and does nothing while the bypass path drives the output. When the loop is unlocked and neither bypass control is set, the output is not guaranteed to hold valid data. The block still passes the reclock path in that case. A flag reports whenever the bypass path owns the output, so a downstream driver can follow the mode. Clock recovery itself sits outside this block. The retimed bit arrives on an input, clocked by the recovered clock.

Top module: `reclk_out_sel`

## Requirements
- R1: In bypass, select code 2'b00 routes input bit 0 to `ser_out`, 2'b01 routes bit 1, 2'b10 routes bit 2 and 2'b11 routes bit 3.
- R2: While `byp_force` is 1, `ser_out` equals the selected input, whatever the value of `lock`.
- R3: With `byp_force` at 0, `byp_auto` at 1 and `lock` at 0, the bypass path drives `ser_out`.
- R4: With `byp_force` at 0 and `lock` at 1, `byp_auto` has no effect, and `ser_out` carries the reclock path.
- R5: `byp_force` at 1 keeps the bypass path selected even when `byp_auto` is 1 and `lock` is 1.
- R6: When the reclock path drives the output and `mute_n` is 0, `ser_out` is 0.
- R7: While bypassed, `mute_n` has no effect, and `ser_out` equals the selected input.
- R8: When `lock` is 0 and both bypass controls are 0, `ser_out` carries the reclock path.
- R9: The reclock path is the value of `rt_data` taken at the previous rising edge of `rclk`. While `rst_n` is low, this register is 0.
- R10: `byp_on` is 1 exactly when the bypass path drives `ser_out`, and it follows the controls without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Recovered clock for the reclock register |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 4 | Four serial data inputs |
| in_sel | input | 2 | Input select code |
| byp_force | input | 1 | Forced bypass, active high |
| byp_auto | input | 1 | Bypass while unlocked, active high |
| mute_n | input | 1 | Mute of the reclock path, active low |
| lock | input | 1 | Clock recovery lock status |
| rt_data | input | 1 | Data bit to be retimed |
| ser_out | output | 1 | Serial output |
| byp_on | output | 1 | High while the bypass path drives the output |

## Verification
The vectors walk through all four select codes, each with a one-hot or a complementary data pattern. A wrong routing therefore shows up as a flipped output bit. The control patterns set bypass against the reclock bit at opposite values, so the observed output shows which path drives it. Each pattern covers one case: forced bypass alone, forced bypass with the automatic bypass also active, the automatic bypass with lock and without it, and mute in each of the two paths. Directed steps check the reset value and the one-edge latency of the reclock path. They also check that the flag follows a change of lock with no clock edge.

// File: rtl/reclk_out_sel.sv
module reclk_out_sel #(
  parameter int N_IN  = 4,
  parameter int SEL_W = $clog2(N_IN)
) (
  input  logic             rclk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  ser_in,
  input  logic [SEL_W-1:0] in_sel,
  input  logic             byp_force,
  input  logic             byp_auto,
  input  logic             mute_n,
  input  logic             lock,
  input  logic             rt_data,
  output logic             ser_out,
  output logic             byp_on
);

  logic rt_q;
  logic raw_bit;
  logic rt_path;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) rt_q <= 1'b0;
    else        rt_q <= rt_data;
  end

  assign raw_bit = ser_in[in_sel];
  assign byp_on  = byp_force | (byp_auto & ~lock);
  assign rt_path = mute_n ? rt_q : 1'b0;
  assign ser_out = byp_on ? raw_bit : rt_path;

  logic seen_edge;
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  p_force_passes_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    byp_force |-> (byp_on && ser_out == ser_in[in_sel]));

  p_auto_unlocked_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (byp_auto && !lock) |-> byp_on);

  p_auto_locked_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    (!byp_force && lock) |-> !byp_on);

  p_mute_quiet_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    (!byp_on && !mute_n) |-> !ser_out);

  p_retime_latency_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    (seen_edge && !byp_on && mute_n) |-> ser_out == $past(rt_data));

  p_unlocked_reclock_r8: assert property (@(posedge rclk) disable iff (!rst_n)
    (!lock && !byp_force && !byp_auto) |-> !byp_on);

endmodule

// File: tb/reclk_out_sel_test.sv
module reclk_out_sel_test;

  logic       rclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ser_in = '0;
  logic [1:0] in_sel = '0;
  logic       byp_force = 1'b0;
  logic       byp_auto = 1'b0;
  logic       mute_n = 1'b1;
  logic       lock = 1'b0;
  logic       rt_data = 1'b0;
  logic       ser_out;
  logic       byp_on;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 rclk = ~rclk;

  reclk_out_sel uut (
    .rclk(rclk), .rst_n(rst_n), .ser_in(ser_in), .in_sel(in_sel),
    .byp_force(byp_force), .byp_auto(byp_auto), .mute_n(mute_n),
    .lock(lock), .rt_data(rt_data), .ser_out(ser_out), .byp_on(byp_on)
  );

  // [16:13] req, [12] force, [11] auto, [10] lock, [9] mute_n,
  // [8:7] sel, [6:3] ser_in, [2] rt_data, [1] exp out, [0] exp flag
  localparam int NV = 19;
  localparam logic [16:0] VEC [NV] = '{
    17'b0001_1001_00_0001_0_11,  // R1 code 00
    17'b0001_1001_01_1101_1_01,  // R1 code 01
    17'b0001_1001_10_0100_0_11,  // R1 code 10
    17'b0001_1001_11_0111_1_01,  // R1 code 11
    17'b0010_1011_10_0100_0_11,  // R2 locked
    17'b0010_1001_01_0010_0_11,  // R2 unlocked
    17'b0011_0101_11_1000_0_11,  // R3
    17'b0100_0111_11_1000_0_00,  // R4 reclock 0
    17'b0100_0111_11_0000_1_10,  // R4 reclock 1
    17'b0101_1111_00_0001_0_11,  // R5
    17'b0110_0010_00_1111_1_00,  // R6 locked, no auto
    17'b0110_0110_00_1111_1_00,  // R6 auto ignored
    17'b0111_1010_01_0010_0_11,  // R7 forced
    17'b0111_0100_00_0001_0_11,  // R7 auto
    17'b1000_0001_00_1111_1_10,  // R8 reclock 1
    17'b1000_0001_00_1111_0_00,  // R8 reclock 0
    17'b1010_0101_10_0000_1_01,  // R10 flag with bypass
    17'b1010_0011_10_1111_0_00,  // R10 flag low
    17'b1010_1011_10_0000_1_01   // R10 forced flag
  };

  task automatic check(input string req, input logic act_o, input logic exp_o,
                       input logic act_f, input logic exp_f);
    n_cmp++;
    if (act_o !== exp_o || act_f !== exp_f) begin
      n_bad++;
      $display("FAIL %s: ser_out=%b byp_on=%b expected ser_out=%b byp_on=%b",
               req, act_o, act_f, exp_o, exp_f);
    end
  endtask

  initial begin
    #150000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9 reset: reclock register held at 0
    rt_data = 1'b1; lock = 1'b1;
    repeat (3) @(posedge rclk);
    #2 check("R9 reset", ser_out, 1'b0, byp_on, 1'b0);
    @(negedge rclk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge rclk);
      byp_force = VEC[i][12]; byp_auto = VEC[i][11]; lock = VEC[i][10];
      mute_n = VEC[i][9]; in_sel = VEC[i][8:7]; ser_in = VEC[i][6:3];
      rt_data = VEC[i][2];
      @(posedge rclk);
      #2 check($sformatf("R%0d vec %0d", VEC[i][16:13], i),
               ser_out, VEC[i][1], byp_on, VEC[i][0]);
    end

    // R9 latency: new reclock bit shows only after a rising edge
    @(negedge rclk);
    byp_force = 0; byp_auto = 0; lock = 1; mute_n = 1; rt_data = 0;
    @(posedge rclk);
    @(negedge rclk) rt_data = 1'b1;
    #2 check("R9 before edge", ser_out, 1'b0, byp_on, 1'b0);
    @(posedge rclk);
    #2 check("R9 after edge", ser_out, 1'b1, byp_on, 1'b0);

    // R10: flag follows lock with no clock edge
    @(negedge rclk);
    byp_auto = 1'b1; in_sel = 2'b10; ser_in = 4'b0000;
    #1 check("R10 locked", ser_out, 1'b1, byp_on, 1'b0);
    lock = 1'b0;
    #1 check("R10 unlock", ser_out, 1'b0, byp_on, 1'b1);

    // R7: mute toggled in bypass leaves output
    mute_n = 1'b0; ser_in = 4'b0100;
    #1 check("R7 mute in bypass", ser_out, 1'b1, byp_on, 1'b1);

    @(negedge rclk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule